// File: doc/BRIEF.md
# Two-Level SCL Timing Generator

This block derives the serial clock of a two-wire bus master from the system clock. A prescaler first divides the system clock by a programmable ratio and produces one tick per division period. Two nested counters then count those ticks. The inner counter counts sample ticks and the outer counter counts steps. One half of the serial clock lasts as many ticks as the product of the two counts, so the bus frequency is the system clock divided by (prescale ratio × 2 × sample count × step count).

The counts come from two configuration words. The normal-speed word sets standard and fast operation. The high-speed word carries its own, narrower pair of counts and a two-bit enable code. When high-speed operation is enabled, a phase input can still force the normal-speed pair. This covers the part of a transfer that must run at fast-mode speed before the bus switches to high speed. Besides the clock level, the block gives two one-cycle strobes for the byte engine: one near the middle of each high half for sampling the data line, and one near the middle of each low half for changing it.

Configuration is read only at half-period boundaries. A change in the middle of a half therefore never shortens or stretches the half that is running. The prescale ratio is an exception: it acts on the next tick.

Top module: `i2c_scl_timegen`

## Requirements
- R1: While reset is asserted and right after its release, `scl_o` is 1 and both strobes are 0.
- R2: With high-speed operation off, every half of `scl_o` lasts P × S × T system clocks. P = `presc_m1`+1. S = `norm_cfg[10:8]`+1. T = `norm_cfg[5:0]`+1.
- R3: The prescale ratio follows `presc_m1`+1. A value of 0 gives one tick per system clock, so a half lasts exactly S × T clocks.
- R4: When `fast_cfg[1:0]` equals 2'b11 and `mc_phase` is 0, each half lasts P × S × T with S = `fast_cfg[14:12]`+1 and T = `fast_cfg[10:8]`+1.
- R5: For any other value of `fast_cfg[1:0]`, the high-speed count fields have no effect and the normal-speed pair sets the period.
- R6: While `mc_phase` is 1, the normal-speed pair sets the period even when `fast_cfg[1:0]` equals 2'b11.
- R7: During each high half, `smp_stb_o` is 1 for exactly one clock. It rises (N/2)×P clocks after the rising edge of `scl_o`, where N = S × T and the division rounds down.
- R8: During each low half, `drv_stb_o` is 1 for exactly one clock. It rises (N/2)×P clocks after the falling edge of `scl_o`.
- R9: A configuration word changed in the middle of a half leaves that half's length unchanged. The new value applies from the next half on.
- R10: The two strobes are never 1 together. A high half carries no drive strobe and a low half carries no sample strobe.
- R11: The maximum counts (sample 8, step 64) give halves of 512 × P clocks, with the strobe at offset 256 × P.

Top module ports are listed in order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_m1 | input | PRE_W | Prescale ratio minus one |
| norm_cfg | input | 16 | Normal-speed counts: sample-1 at [10:8], step-1 at [5:0] |
| fast_cfg | input | 16 | High-speed counts: sample-1 at [14:12], step-1 at [10:8]; enable code at [1:0] |
| mc_phase | input | 1 | Forces the normal-speed pair while 1 |
| scl_o | output | 1 | Serial clock level |
| smp_stb_o | output | 1 | One-cycle strobe for sampling the data line during the high half |
| drv_stb_o | output | 1 | One-cycle strobe for changing the data line during the low half |

## Verification
A wrong count in the sample or step counter, or a latched count pair that went stale, shows up at the first `scl_o` edge after it. That edge comes early or late by a multiple of P, so the error is visible within one half period. A faulty mid-point value moves a strobe away from offset (N/2)×P, or removes or doubles it, inside the same half. A faulty mode selection gives a half length that matches the other count pair. The half that follows a configuration change shows whether a value was taken up too early.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  localparam int SMP_W      = 3;
  localparam int STP_W      = 6;
  localparam int HS_STP_W   = 3;
  localparam int TREG_W     = 16;
  localparam int NORM_SMP_LSB = 8;
  localparam int NORM_STP_LSB = 0;
  localparam int FAST_SMP_LSB = 12;
  localparam int FAST_STP_LSB = 8;
  localparam int HCNT_W     = SMP_W + STP_W + 1;
  localparam logic [1:0] FAST_ON_CODE = 2'b11;

  typedef struct packed {
    logic [SMP_W-1:0] smp_m1;
    logic [STP_W-1:0] stp_m1;
  } tg_cnt_t;
endpackage

// File: rtl/scl_tg_presc.sv
module scl_tg_presc #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] ratio_m1,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;

  assign tick = en && (pcnt_q >= ratio_m1);

  always_comb begin
    if (!en || tick) pcnt_d = '0;
    else             pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3: with a ratio above one, a tick is never followed at once by another
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio_m1 != '0) |=> (!tick || ratio_m1 == '0));
endmodule

// File: rtl/scl_tg_cfgsel.sv
module scl_tg_cfgsel
  import scl_tg_pkg::*;
(
  input  logic [TREG_W-1:0] norm_cfg,
  input  logic [TREG_W-1:0] fast_cfg,
  input  logic              mc_phase,
  output tg_cnt_t           cnt,
  output logic [HCNT_W-1:0] mid
);
  logic              fast_sel;
  logic [HCNT_W-1:0] prod;

  always_comb begin
    fast_sel = (fast_cfg[1:0] == FAST_ON_CODE) && !mc_phase;
    if (fast_sel) begin
      cnt.smp_m1 = fast_cfg[FAST_SMP_LSB +: SMP_W];
      cnt.stp_m1 = STP_W'(fast_cfg[FAST_STP_LSB +: HS_STP_W]);
    end else begin
      cnt.smp_m1 = norm_cfg[NORM_SMP_LSB +: SMP_W];
      cnt.stp_m1 = norm_cfg[NORM_STP_LSB +: STP_W];
    end
    prod = (HCNT_W'(cnt.smp_m1) + 1'b1) * (HCNT_W'(cnt.stp_m1) + 1'b1);
    mid  = prod >> 1;
  end
endmodule

// File: rtl/scl_tg_halfcnt.sv
module scl_tg_halfcnt
  import scl_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  tg_cnt_t           cfg,
  input  logic [HCNT_W-1:0] cfg_mid,
  output logic              primed,
  output logic              half_end,
  output logic              mid_reach
);
  tg_cnt_t           act_q, act_d;
  logic [HCNT_W-1:0] mid_q, mid_d;
  logic [SMP_W-1:0]  smp_q, smp_d;
  logic [STP_W-1:0]  stp_q, stp_d;
  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic              primed_q, primed_d;
  logic              last;

  assign primed   = primed_q;
  assign last     = (smp_q == act_q.smp_m1) && (stp_q == act_q.stp_m1);
  assign half_end = primed_q && tick && last;

  always_comb begin
    act_d    = act_q;
    mid_d    = mid_q;
    smp_d    = smp_q;
    stp_d    = stp_q;
    hcnt_d   = hcnt_q;
    primed_d = 1'b1;
    mid_reach = 1'b0;
    if (!primed_q) begin
      act_d  = cfg;
      mid_d  = cfg_mid;
      smp_d  = '0;
      stp_d  = '0;
      hcnt_d = '0;
      mid_reach = (cfg_mid == '0);
    end else if (tick) begin
      if (last) begin
        act_d  = cfg;
        mid_d  = cfg_mid;
        smp_d  = '0;
        stp_d  = '0;
        hcnt_d = '0;
        mid_reach = (cfg_mid == '0);
      end else begin
        hcnt_d = hcnt_q + 1'b1;
        mid_reach = ((hcnt_q + 1'b1) == mid_q);
        if (smp_q == act_q.smp_m1) begin
          smp_d = '0;
          stp_d = stp_q + 1'b1;
        end else begin
          smp_d = smp_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= '0;
      mid_q    <= '0;
      smp_q    <= '0;
      stp_q    <= '0;
      hcnt_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      act_q    <= act_d;
      mid_q    <= mid_d;
      smp_q    <= smp_d;
      stp_q    <= stp_d;
      hcnt_q   <= hcnt_d;
      primed_q <= primed_d;
    end
  end

  // R9: the latched count pair changes only at a half boundary
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !half_end) |=> ($stable(act_q) && $stable(mid_q)));

  // R2: both counters stay inside the latched range
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_q <= act_q.smp_m1) && (stp_q <= act_q.stp_m1));
endmodule

// File: rtl/i2c_scl_timegen.sv
module i2c_scl_timegen
  import scl_tg_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  presc_m1,
  input  logic [TREG_W-1:0] norm_cfg,
  input  logic [TREG_W-1:0] fast_cfg,
  input  logic              mc_phase,
  output logic              scl_o,
  output logic              smp_stb_o,
  output logic              drv_stb_o
);
  tg_cnt_t           sel_cnt;
  logic [HCNT_W-1:0] sel_mid;
  logic              tick, primed, half_end, mid_reach;
  logic              scl_q, scl_d, smp_q, smp_d, drv_q, drv_d;
  logic              half_lvl;

  scl_tg_cfgsel u_sel (
    .norm_cfg (norm_cfg),
    .fast_cfg (fast_cfg),
    .mc_phase (mc_phase),
    .cnt      (sel_cnt),
    .mid      (sel_mid)
  );

  scl_tg_presc #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (primed),
    .ratio_m1 (presc_m1),
    .tick     (tick)
  );

  scl_tg_halfcnt u_half (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cfg       (sel_cnt),
    .cfg_mid   (sel_mid),
    .primed    (primed),
    .half_end  (half_end),
    .mid_reach (mid_reach)
  );

  always_comb begin
    scl_d    = half_end ? !scl_q : scl_q;
    half_lvl = scl_d;
    smp_d    = mid_reach && half_lvl;
    drv_d    = mid_reach && !half_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      smp_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      scl_q <= scl_d;
      smp_q <= smp_d;
      drv_q <= drv_d;
    end
  end

  assign scl_o     = scl_q;
  assign smp_stb_o = smp_q;
  assign drv_stb_o = drv_q;

  // R10: strobes are exclusive
  p_stb_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_q && drv_q));
  // R7: sample strobe only inside a high half
  p_smp_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_q |-> scl_q);
  // R8: drive strobe only inside a low half
  p_drv_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> !scl_q);
  // R2: SCL moves only after a half boundary from the counter pair
  p_scl_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q != $past(scl_q)) |-> $past(half_end));
endmodule

// File: tb/sim_i2c_scl_timegen.sv
module sim_i2c_scl_timegen;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  presc_m1;
  logic [15:0] norm_cfg, fast_cfg;
  logic        mc_phase;
  logic        scl_o, smp_stb_o, drv_stb_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_timegen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_m1  (presc_m1),
    .norm_cfg  (norm_cfg),
    .fast_cfg  (fast_cfg),
    .mc_phase  (mc_phase),
    .scl_o     (scl_o),
    .smp_stb_o (smp_stb_o),
    .drv_stb_o (drv_stb_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act %0d cycles exp <= %0d", cyc, WDOG_LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] norm_word(input int s, input int t);
    logic [15:0] w = '0;
    w[10:8] = 3'(s - 1);
    w[5:0]  = 6'(t - 1);
    return w;
  endfunction

  function automatic logic [15:0] fast_word(input int s, input int t, input logic [1:0] en);
    logic [15:0] w = '0;
    w[14:12] = 3'(s - 1);
    w[10:8]  = 3'(t - 1);
    w[1:0]   = en;
    return w;
  endfunction

  task automatic sync_edge();
    logic lvl;
    @(negedge clk);
    lvl = scl_o;
    do @(negedge clk); while (scl_o == lvl);
  endtask

  // Called at the negedge just after an SCL toggle; returns at the next one.
  task automatic observe_half(output logic lvl, output int len,
                              output int n_s, output int n_d, output int off);
    int o = 0;
    lvl = scl_o; n_s = 0; n_d = 0; off = -1;
    forever begin
      if (o > 0 && scl_o != lvl) break;
      if (smp_stb_o) begin n_s++; if (off < 0) off = o; end
      if (drv_stb_o) begin n_d++; if (off < 0) off = o; end
      @(negedge clk);
      o++;
    end
    len = o;
  endtask

  task automatic check_half(input string req, input int p, input int n);
    logic lvl; int len, ns, nd, off;
    observe_half(lvl, len, ns, nd, off);
    chk(len == p*n, {req, " half length"}, len, p*n);
    if (lvl) chk(ns == 1 && nd == 0, {req, " R7 R10 high-half strobes"}, ns*10+nd, 10);
    else     chk(nd == 1 && ns == 0, {req, " R8 R10 low-half strobes"}, ns*10+nd, 1);
    chk(off == (n/2)*p, {req, " strobe offset"}, off, (n/2)*p);
  endtask

  task automatic run_pair(input string req, input int p, input int n);
    sync_edge();
    check_half(req, p, n);
    check_half(req, p, n);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    presc_m1 = 4'd3; norm_cfg = norm_word(3, 5); fast_cfg = '0; mc_phase = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1, "R1 scl in reset", scl_o, 1);
    chk(!smp_stb_o && !drv_stb_o, "R1 strobes in reset", smp_stb_o + drv_stb_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(scl_o == 1'b1, "R1 scl after release", scl_o, 1);
  endtask

  task automatic t_norm();
    presc_m1 = 4'd3; norm_cfg = norm_word(3, 5); fast_cfg = '0; mc_phase = 1'b0;
    run_pair("R2", 4, 15);
  endtask

  task automatic t_presc();
    presc_m1 = 4'd0; norm_cfg = norm_word(2, 3);
    run_pair("R3", 1, 6);
  endtask

  task automatic t_fast();
    presc_m1 = 4'd1; norm_cfg = norm_word(5, 7); fast_cfg = fast_word(4, 2, 2'b11);
    mc_phase = 1'b0;
    run_pair("R4", 2, 8);
  endtask

  task automatic t_fast_off();
    presc_m1 = 4'd1; norm_cfg = norm_word(3, 3); fast_cfg = fast_word(4, 2, 2'b01);
    run_pair("R5", 2, 9);
    fast_cfg = fast_word(4, 2, 2'b10);
    run_pair("R5", 2, 9);
  endtask

  task automatic t_mcode();
    presc_m1 = 4'd1; norm_cfg = norm_word(2, 5); fast_cfg = fast_word(8, 8, 2'b11);
    mc_phase = 1'b1;
    run_pair("R6", 2, 10);
    mc_phase = 1'b0;
  endtask

  task automatic t_midchange();
    presc_m1 = 4'd1; norm_cfg = norm_word(2, 2); fast_cfg = '0; mc_phase = 1'b0;
    sync_edge();
    sync_edge();
    norm_cfg = norm_word(4, 3);
    check_half("R9 old value kept", 2, 4);
    check_half("R9 new value used", 2, 12);
  endtask

  task automatic t_max();
    presc_m1 = 4'd0; norm_cfg = norm_word(8, 64);
    run_pair("R11", 1, 512);
  endtask

  task automatic t_min();
    presc_m1 = 4'd1; norm_cfg = norm_word(1, 1);
    run_pair("R7 R8 single-tick", 2, 1);
  endtask

  initial begin
    t_reset();
    t_norm();
    t_presc();
    t_fast();
    t_fast_off();
    t_mcode();
    t_midchange();
    t_max();
    t_min();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule